// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that software programs through a small synchronous register port. Software loads a tick count into a timer-value register and then starts the timer. The timer counts down once for each pulse on an external tick-enable input. The first expiry records a timeout status, optionally raises a one-cycle system-management interrupt request, and reloads the count. If a second expiry follows with no software reload in between, the block sets second-timeout and boot flags. It can then raise a reset request, unless a strap input or a no-reboot input holds it back.

The register port has a write strobe, a 4-bit address, 16-bit write data and combinational read data. The block also has data-in and data-out mailbox bytes. Writing them has side effects on status bits and on the interrupt-request output. A lock bit in control register 1 stays set until block reset once software sets it.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, the registers read as follows (address in brackets): reload [0] 0, data-in [1] 0, data-out [2] 0, status1 [3] 0, status2 [4] 0, control1 [5] 0, control2 [6] 0x0008, message1 [7] 0, message2 [8] 0, watchdog-count [9] 0, timer-value [10] 0x0004, sw-irq-gen [11] 0x0003. The outputs smi_pulse, int_sts and rst_req are low. The timer is stopped.
- R2: The timer runs only while control1 bit 0 (halt) is clear and the 10-bit timer-value register holds more than 1. While it runs, each tick_en pulse lowers the count by one. Reading the reload address returns the live count. A stopped timer ignores tick_en, and the reload address keeps its stored value.
- R3: After a start from value N, the N-th tick is an expiry. An expiry sets status1 bit 0 (timeout), reloads the count from timer-value, and counting continues.
- R4: A non-fatal expiry drives smi_pulse high for exactly the one cycle after the expiring edge, but only if smi_en is high. If smi_en is low, smi_pulse stays low.
- R5: An expiry that follows an earlier expiry with no reload write in between is a second expiry. It sets status2 bit 0 (second timeout) and bit 1 (boot), and the consecutive count goes back to zero.
- R6: On a second expiry with strap_hi low and no_reboot low, rst_req goes high and stays high until block reset. The count becomes 0, the timer stops, and no SMI is raised. If either input is high, the expiry behaves as in R3 and R4.
- R7: A write to the reload address clears the consecutive count. If the R2 run condition holds, the count restarts from timer-value. Otherwise the timer stops and the reload address stores the write data.
- R8: Each write to control1 evaluates the run condition with the newly written value. The timer restarts from timer-value if the condition holds and stops (count frozen) if it does not.
- R9: Control1 bit 1 (lock) can be set by software but not cleared. Only block reset clears it.
- R10: A data-in write stores the low byte, sets status1 bit 1 and pulses smi_pulse in the next cycle. A data-out write stores the low byte and sets status1 bit 2. The int_sts output mirrors status1 bit 2.
- R11: Status1 writes keep bits [2:0] only, and status2 writes keep bits [1:0] only; other bits read 0. An event that sets a status bit in the same cycle as a status write takes precedence over the written value.
- R12: A reload write in the same cycle as an expiring tick takes precedence. That expiry is dropped: no status, no SMI, no consecutive count. The count restarts as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Read data for addr (combinational) |
| tick_en | input | 1 | Countdown tick enable, one cycle per tick |
| smi_en | input | 1 | Allows SMI on expiry |
| no_reboot | input | 1 | High blocks the reset request |
| strap_hi | input | 1 | High blocks the reset request |
| smi_pulse | output | 1 | One-cycle system-management interrupt request |
| int_sts | output | 1 | Interrupt status flag (status1 bit 2) |
| rst_req | output | 1 | Sticky platform reset request |

## Verification
A software write and an expiring tick can land on the same clock edge. The two cases here are a reload write, where the write must win and the expiry vanish, and a status1 clear, where the timeout bit must survive. The bench provokes both by running the count down to 1 and then driving tick_en and the write strobe in the same cycle. It then reads status1, the reload value and smi_pulse through the port and compares them with the outcomes that R11 and R12 demand.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [3:0] {
    A_RELOAD = 4'd0,
    A_DIN    = 4'd1,
    A_DOUT   = 4'd2,
    A_STAT1  = 4'd3,
    A_STAT2  = 4'd4,
    A_CTRL1  = 4'd5,
    A_CTRL2  = 4'd6,
    A_MSG1   = 4'd7,
    A_MSG2   = 4'd8,
    A_WDCNT  = 4'd9,
    A_TVAL   = 4'd10,
    A_SWIRQ  = 4'd11
  } wdog_addr_e;

  localparam int unsigned ST1_W       = 3;
  localparam int unsigned ST1_TIMEOUT = 0;
  localparam int unsigned ST1_SWSMI   = 1;
  localparam int unsigned ST1_INT     = 2;
  localparam int unsigned ST2_W       = 2;
  localparam int unsigned C1_W        = 2;
  localparam int unsigned C1_HALT     = 0;
  localparam int unsigned C1_LOCK     = 1;
  localparam int unsigned BYTE_W      = 8;

  localparam logic [15:0] CTRL2_RST = 16'h0008;
  localparam logic [7:0]  SWIRQ_RST = 8'h03;
  localparam int unsigned TVAL_RST  = 4;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int unsigned TVAL_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              restart,
  input  logic              store,
  input  logic              stop,
  input  logic [DATA_W-1:0] store_data,
  input  logic [TVAL_W-1:0] tval,
  input  logic              fatal,
  output logic              expire,
  output logic              running,
  output logic [DATA_W-1:0] cnt
);
  localparam logic [TVAL_W-1:0] ONE = TVAL_W'(1);

  logic              run_q, run_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              sw_touch;

  assign sw_touch = restart | store | stop;
  assign expire   = run_q & tick_en & ~sw_touch & (cnt_q[TVAL_W-1:0] <= ONE);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (restart) begin
      run_d = 1'b1;
      cnt_d = DATA_W'(tval);
    end else if (store) begin
      run_d = 1'b0;
      cnt_d = store_data;
    end else if (stop) begin
      run_d = 1'b0;
    end else if (expire) begin
      if (fatal) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = DATA_W'(tval);
      end
    end else if (run_q && tick_en) begin
      cnt_d = cnt_q - DATA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign running = run_q;
  assign cnt     = cnt_q;
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  input  logic strap_hi,
  input  logic no_reboot,
  output logic second,
  output logic fatal,
  output logic rst_req
);
  logic armed_q, armed_d;
  logic req_q, req_d;

  assign second = expire & armed_q;
  assign fatal  = second & ~strap_hi & ~no_reboot;

  always_comb begin
    armed_d = armed_q;
    if (clr)         armed_d = 1'b0;
    else if (expire) armed_d = ~armed_q;
    req_d = req_q | fatal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      req_q   <= req_d;
    end
  end

  assign rst_req = req_q;
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned TVAL_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick_en,
  input  logic              smi_en,
  input  logic              no_reboot,
  input  logic              strap_hi,
  output logic              smi_pulse,
  output logic              int_sts,
  output logic              rst_req
);
  localparam logic [TVAL_W-1:0] TVAL_INIT = TVAL_W'(TVAL_RST);
  localparam logic [TVAL_W-1:0] TVAL_MIN  = TVAL_W'(1);

  logic srst_n;
  wdog_rst_sync u_rsync (.clk(clk), .rst_n_i(rst_n), .rst_n_o(srst_n));

  // register state
  logic [BYTE_W-1:0] din_q, din_d, dout_q, dout_d;
  logic [BYTE_W-1:0] msg1_q, msg1_d, msg2_q, msg2_d, wdcnt_q, wdcnt_d;
  logic [BYTE_W-1:0] swirq_q, swirq_d;
  logic [ST1_W-1:0]  stat1_q, stat1_d;
  logic [ST2_W-1:0]  stat2_q, stat2_d;
  logic [C1_W-1:0]   ctrl1_q, ctrl1_d, ctrl1_new;
  logic [DATA_W-1:0] ctrl2_q, ctrl2_d;
  logic [TVAL_W-1:0] tval_q, tval_d;
  logic              smi_q, smi_d;

  // write decode
  logic wr_reload, wr_din, wr_dout, wr_st1, wr_st2, wr_c1, wr_c2;
  logic wr_m1, wr_m2, wr_wdc, wr_tval, wr_swirq;
  assign wr_reload = wr_en && (addr == A_RELOAD);
  assign wr_din    = wr_en && (addr == A_DIN);
  assign wr_dout   = wr_en && (addr == A_DOUT);
  assign wr_st1    = wr_en && (addr == A_STAT1);
  assign wr_st2    = wr_en && (addr == A_STAT2);
  assign wr_c1     = wr_en && (addr == A_CTRL1);
  assign wr_c2     = wr_en && (addr == A_CTRL2);
  assign wr_m1     = wr_en && (addr == A_MSG1);
  assign wr_m2     = wr_en && (addr == A_MSG2);
  assign wr_wdc    = wr_en && (addr == A_WDCNT);
  assign wr_tval   = wr_en && (addr == A_TVAL);
  assign wr_swirq  = wr_en && (addr == A_SWIRQ);

  // run condition, old and newly written control value
  logic run_ok_cur, run_ok_new;
  assign ctrl1_new  = wr_data[C1_W-1:0] | {ctrl1_q[C1_LOCK], 1'b0};
  assign run_ok_cur = !ctrl1_q[C1_HALT] && (tval_q > TVAL_MIN);
  assign run_ok_new = !ctrl1_new[C1_HALT] && (tval_q > TVAL_MIN);

  logic restart, store, stop;
  assign restart = (wr_reload && run_ok_cur) || (wr_c1 && run_ok_new);
  assign store   = wr_reload && !run_ok_cur;
  assign stop    = wr_c1 && !run_ok_new;

  logic              expire, running, second, fatal;
  logic [DATA_W-1:0] cnt;

  wdog_countdown #(.TVAL_W(TVAL_W), .DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .tick_en(tick_en),
    .restart(restart), .store(store), .stop(stop),
    .store_data(wr_data), .tval(tval_q), .fatal(fatal),
    .expire(expire), .running(running), .cnt(cnt)
  );

  wdog_escalate u_esc (
    .clk(clk), .rst_n(srst_n), .expire(expire), .clr(wr_reload),
    .strap_hi(strap_hi), .no_reboot(no_reboot),
    .second(second), .fatal(fatal), .rst_req(rst_req)
  );

  // next-state logic
  always_comb begin
    din_d   = wr_din   ? wr_data[BYTE_W-1:0] : din_q;
    dout_d  = wr_dout  ? wr_data[BYTE_W-1:0] : dout_q;
    msg1_d  = wr_m1    ? wr_data[BYTE_W-1:0] : msg1_q;
    msg2_d  = wr_m2    ? wr_data[BYTE_W-1:0] : msg2_q;
    wdcnt_d = wr_wdc   ? wr_data[BYTE_W-1:0] : wdcnt_q;
    swirq_d = wr_swirq ? wr_data[BYTE_W-1:0] : swirq_q;
    ctrl2_d = wr_c2    ? wr_data             : ctrl2_q;
    tval_d  = wr_tval  ? wr_data[TVAL_W-1:0] : tval_q;
    ctrl1_d = wr_c1    ? ctrl1_new           : ctrl1_q;

    stat1_d = wr_st1 ? wr_data[ST1_W-1:0] : stat1_q;
    stat1_d[ST1_TIMEOUT] = stat1_d[ST1_TIMEOUT] | expire;
    stat1_d[ST1_SWSMI]   = stat1_d[ST1_SWSMI]   | wr_din;
    stat1_d[ST1_INT]     = stat1_d[ST1_INT]     | wr_dout;

    stat2_d = (wr_st2 ? wr_data[ST2_W-1:0] : stat2_q) | {ST2_W{second}};

    smi_d = wr_din | (expire & smi_en & ~fatal);
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      din_q   <= '0;
      dout_q  <= '0;
      msg1_q  <= '0;
      msg2_q  <= '0;
      wdcnt_q <= '0;
      swirq_q <= SWIRQ_RST;
      ctrl2_q <= CTRL2_RST;
      tval_q  <= TVAL_INIT;
      ctrl1_q <= '0;
      stat1_q <= '0;
      stat2_q <= '0;
      smi_q   <= 1'b0;
    end else begin
      din_q   <= din_d;
      dout_q  <= dout_d;
      msg1_q  <= msg1_d;
      msg2_q  <= msg2_d;
      wdcnt_q <= wdcnt_d;
      swirq_q <= swirq_d;
      ctrl2_q <= ctrl2_d;
      tval_q  <= tval_d;
      ctrl1_q <= ctrl1_d;
      stat1_q <= stat1_d;
      stat2_q <= stat2_d;
      smi_q   <= smi_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_RELOAD: rd_data = cnt;
      A_DIN:    rd_data = DATA_W'(din_q);
      A_DOUT:   rd_data = DATA_W'(dout_q);
      A_STAT1:  rd_data = DATA_W'(stat1_q);
      A_STAT2:  rd_data = DATA_W'(stat2_q);
      A_CTRL1:  rd_data = DATA_W'(ctrl1_q);
      A_CTRL2:  rd_data = ctrl2_q;
      A_MSG1:   rd_data = DATA_W'(msg1_q);
      A_MSG2:   rd_data = DATA_W'(msg2_q);
      A_WDCNT:  rd_data = DATA_W'(wdcnt_q);
      A_TVAL:   rd_data = DATA_W'(tval_q);
      A_SWIRQ:  rd_data = DATA_W'(swirq_q);
      default:  rd_data = '0;
    endcase
  end

  assign smi_pulse = smi_q;
  assign int_sts   = stat1_q[ST1_INT];
endmodule

// File: rtl/twostage_wdog_chk.sv
module twostage_wdog_chk
  import wdog_pkg::*;
#(
  parameter int unsigned TVAL_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [3:0]        addr,
  input logic              smi_en,
  input logic [C1_W-1:0]   ctrl1,
  input logic [TVAL_W-1:0] tval,
  input logic [DATA_W-1:0] cnt,
  input logic              running,
  input logic [ST2_W-1:0]  stat2,
  input logic              smi_pulse,
  input logic              rst_req
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl1[C1_LOCK] |=> ctrl1[C1_LOCK]); // R9

  AST_RST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req); // R6

  AST_RST_REQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (stat2 == 2'b11)); // R5

  AST_RELOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_RELOAD && !ctrl1[C1_HALT] && tval > TVAL_W'(1))
      |=> (running && cnt == DATA_W'($past(tval)))); // R7

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_en) |=> $stable(cnt)); // R2

  AST_DIN_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIN) |=> smi_pulse); // R10

  AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> $past((wr_en && addr == A_DIN) || smi_en)); // R4
endmodule

bind twostage_wdog twostage_wdog_chk #(.TVAL_W(TVAL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .addr(addr), .smi_en(smi_en),
  .ctrl1(ctrl1_q), .tval(tval_q), .cnt(cnt), .running(running),
  .stat2(stat2_q), .smi_pulse(smi_pulse), .rst_req(rst_req)
);

// File: tb/twostage_wdog_tb.sv
module twostage_wdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] rd_data;
  logic        tick_en = 1'b0;
  logic        smi_en = 1'b1;
  logic        no_reboot = 1'b0;
  logic        strap_hi = 1'b1;
  logic        smi_pulse, int_sts, rst_req;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] RLD = 4'd0, DIN = 4'd1, DOUT = 4'd2, ST1 = 4'd3,
    ST2 = 4'd4, C1 = 4'd5, C2 = 4'd6, M1 = 4'd7, M2 = 4'd8, WDC = 4'd9,
    TV = 4'd10, SWI = 4'd11;

  always #2 clk = ~clk;

  twostage_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tick_en(tick_en), .smi_en(smi_en),
    .no_reboot(no_reboot), .strap_hi(strap_hi), .smi_pulse(smi_pulse),
    .int_sts(int_sts), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic tick_with_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset_values();
    rchk("R1 reload", RLD, 16'h0);
    rchk("R1 din", DIN, 16'h0);
    rchk("R1 dout", DOUT, 16'h0);
    rchk("R1 stat1", ST1, 16'h0);
    rchk("R1 stat2", ST2, 16'h0);
    rchk("R1 ctrl1", C1, 16'h0);
    rchk("R1 ctrl2", C2, 16'h0008);
    rchk("R1 msg1", M1, 16'h0);
    rchk("R1 msg2", M2, 16'h0);
    rchk("R1 wdcnt", WDC, 16'h0);
    rchk("R1 tval", TV, 16'h0004);
    rchk("R1 swirq", SWI, 16'h0003);
    chk("R1 outputs", {13'h0, smi_pulse, int_sts, rst_req}, 16'h0);
    ticks(2);
    rchk("R1 stopped after reset", RLD, 16'h0);
  endtask

  task automatic t_countdown_halt();
    wr(TV, 16'd5);
    wr(C1, 16'h0);
    rchk("R8 start on ctrl1 write", RLD, 16'd5);
    ticks(2);
    rchk("R2 count down", RLD, 16'd3);
    wr(C1, 16'h0001);
    ticks(2);
    rchk("R8 halt freezes count", RLD, 16'd3);
    wr(C1, 16'h0000);
    rchk("R8 restart on halt clear", RLD, 16'd5);
  endtask

  task automatic t_first_second();
    ticks(4);
    rchk("R3 before expiry", ST1, 16'h0);
    tick();
    chk("R4 smi on first expiry", {15'h0, smi_pulse}, 16'h1);
    rchk("R3 timeout bit", ST1, 16'h0001);
    rchk("R3 reload after expiry", RLD, 16'd5);
    rchk("R3 no second yet", ST2, 16'h0);
    @(negedge clk);
    chk("R4 smi one cycle", {15'h0, smi_pulse}, 16'h0);
    ticks(5);
    rchk("R5 second flags", ST2, 16'h0003);
    chk("R6 strap blocks reset", {15'h0, rst_req}, 16'h0);
    chk("R6 strap keeps smi", {15'h0, smi_pulse}, 16'h1);
    rchk("R6 strap keeps reloading", RLD, 16'd5);
  endtask

  task automatic t_reload_write();
    wr(ST2, 16'h0);
    ticks(5);
    rchk("R7 setup expiry", ST1, 16'h0001);
    wr(RLD, 16'h0000);
    rchk("R7 reload restarts", RLD, 16'd5);
    ticks(5);
    rchk("R7 reload clears consecutive count", ST2, 16'h0);
    wr(TV, 16'd1);
    wr(RLD, 16'h0123);
    rchk("R7 store when not runnable", RLD, 16'h0123);
    ticks(2);
    rchk("R2 value one never runs", RLD, 16'h0123);
    wr(C1, 16'h0);
    ticks(2);
    rchk("R8 ctrl1 write with tval 1 stays stopped", RLD, 16'h0123);
  endtask

  task automatic t_smi_disabled();
    do_reset();
    smi_en = 1'b0;
    wr(TV, 16'd2);
    wr(C1, 16'h0);
    ticks(2);
    chk("R4 no smi when disabled", {15'h0, smi_pulse}, 16'h0);
    rchk("R4 timeout still recorded", ST1, 16'h0001);
    smi_en = 1'b1;
  endtask

  task automatic t_fatal();
    do_reset();
    strap_hi = 1'b0; no_reboot = 1'b0;
    wr(TV, 16'd2);
    wr(C1, 16'h0);
    ticks(2);
    chk("R6 no reset on first expiry", {15'h0, rst_req}, 16'h0);
    ticks(2);
    chk("R6 reset request", {15'h0, rst_req}, 16'h1);
    chk("R6 no smi on fatal", {15'h0, smi_pulse}, 16'h0);
    rchk("R6 count zero", RLD, 16'h0);
    rchk("R5 flags on fatal", ST2, 16'h0003);
    ticks(2);
    rchk("R6 timer stopped", RLD, 16'h0);
    chk("R6 request held", {15'h0, rst_req}, 16'h1);
    strap_hi = 1'b1;
    do_reset();
    chk("R6 request cleared by reset", {15'h0, rst_req}, 16'h0);
  endtask

  task automatic t_noreboot();
    strap_hi = 1'b0; no_reboot = 1'b1;
    wr(TV, 16'd2);
    wr(C1, 16'h0);
    ticks(4);
    chk("R6 no_reboot blocks reset", {15'h0, rst_req}, 16'h0);
    chk("R6 no_reboot keeps smi", {15'h0, smi_pulse}, 16'h1);
    rchk("R6 no_reboot reloads", RLD, 16'd2);
    rchk("R5 flags with no_reboot", ST2, 16'h0003);
    strap_hi = 1'b1; no_reboot = 1'b0;
  endtask

  task automatic t_data();
    do_reset();
    wr(DIN, 16'h12A5);
    chk("R10 din smi", {15'h0, smi_pulse}, 16'h1);
    rchk("R10 din byte", DIN, 16'h00A5);
    rchk("R10 swsmi bit", ST1, 16'h0002);
    chk("R10 int_sts low", {15'h0, int_sts}, 16'h0);
    wr(DOUT, 16'h345A);
    rchk("R10 dout byte", DOUT, 16'h005A);
    rchk("R10 int bit", ST1, 16'h0006);
    chk("R10 int_sts high", {15'h0, int_sts}, 16'h1);
  endtask

  task automatic t_status();
    wr(ST1, 16'hFFFF);
    rchk("R11 stat1 mask", ST1, 16'h0007);
    wr(ST2, 16'hFFFF);
    rchk("R11 stat2 mask", ST2, 16'h0003);
    wr(ST1, 16'h0);
    rchk("R11 stat1 cleared", ST1, 16'h0);
    wr(TV, 16'd2);
    wr(C1, 16'h0);
    tick();
    tick_with_wr(ST1, 16'h0000);
    rchk("R11 set beats write", ST1, 16'h0001);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(TV, 16'd3);
    wr(C1, 16'h0);
    ticks(2);
    rchk("R12 count at one", RLD, 16'd1);
    tick_with_wr(RLD, 16'h0000);
    chk("R12 no smi", {15'h0, smi_pulse}, 16'h0);
    rchk("R12 expiry dropped", ST1, 16'h0);
    rchk("R12 restarted", RLD, 16'd3);
    ticks(3);
    rchk("R12 later expiry is first", ST1, 16'h0001);
    rchk("R12 later expiry no second", ST2, 16'h0);
  endtask

  task automatic t_lock();
    wr(C1, 16'h0002);
    rchk("R9 lock set", C1, 16'h0002);
    wr(C1, 16'h0000);
    rchk("R9 lock not cleared", C1, 16'h0002);
    wr(C1, 16'h0001);
    rchk("R9 halt with lock", C1, 16'h0003);
    do_reset();
    rchk("R9 reset clears lock", C1, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_values();
    t_countdown_halt();
    t_first_second();
    t_reload_write();
    t_smi_disabled();
    t_fatal();
    t_noreboot();
    t_data();
    t_status();
    t_same_cycle();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule